// File: doc/BRIEF.md
# Delta-Sigma Converter Frame Reader

This block is the host side of a three-wire serial link to a 24-bit delta-sigma converter that reports each conversion as a 32-bit word. A one-cycle `start` pulse makes it pull chip select low and watch the converter's data line. That line stays high while a conversion is still running. When it drops low, the reader drives a serial clock whose half period is set by `div_cfg`. It takes one data bit on every rising edge of that clock, most significant bit first, for 32 edges.

When the word is complete, the reader releases chip select and pulses `valid` for one clock. With that pulse it presents the decoded measurement. The value is a 26-bit two's-complement number built from the sign and range status bits and the 24 result bits, so it spans -1/8 to +9/8 of full scale. The reader also presents the out-of-range flag, the four sub-LSB bits and a frame-error flag. If the data line never drops within the programmed wait, the reader gives up, releases chip select and pulses `timeout`.

Top module: `adc_frame_reader`

## Requirements
- R1: While `rst` is high and in the cycle after it, `adc_cs_n` is 1, `adc_sck` is 0, and `valid`, `timeout` and `frame_err` are 0.
- R2: A `start` seen in idle drives `adc_cs_n` low in the next cycle. While the reader waits for `adc_sdo` to fall, `adc_sck` stays low.
- R3: Suppose `adc_sdo` is still high on the (`timeout_cfg`+1)-th clock after chip select went low. On that clock the reader raises `adc_cs_n`, pulses `timeout` for exactly one cycle, and gives no `valid`.
- R4: Once `adc_sdo` is seen low, the reader issues exactly 32 rising edges on `adc_sck`. Each high and low phase lasts `div_cfg`+1 clocks, with only the final high phase cut to one clock. A bit is taken on every rising edge.
- R5: Bits arrive MSB first, frame bit 31 first. Frame bits 3..0 appear on `sub_lsb` with bit 3 as the MSB.
- R6: Let frame bit 29 be the sign (1 = positive), bit 28 the range flag, and bits 27..4 the result. `result` is {inverted sign, range flag, result bits} read as 26-bit two's complement. Anchor codes: zero gives 0, minus one LSB gives -1, full scale gives 2^24-1, -1/8 scale gives -2^21, and +9/8 scale gives 2^24+2^21-1.
- R7: `out_of_range` equals frame bit 28.
- R8: `frame_err` is 1 when frame bit 30 (which must read 0) or frame bit 31 (end-of-conversion, must read 0) is 1.
- R9: Chip select goes high one clock after the 32nd rising edge. `valid` is high for exactly that one clock, together with the new outputs. Chip select is low for W + 63·(`div_cfg`+1) + 1 clocks in total, where W is the number of wait clocks up to and including the one that saw `adc_sdo` low.
- R10: `start` has no effect while a frame is in progress. No second chip-select cycle follows the current one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one read, taken only when idle |
| div_cfg | input | DIV_W | Serial clock half period minus one, in clocks |
| timeout_cfg | input | TO_W | Wait budget for end-of-conversion, minus one |
| adc_sdo | input | 1 | Converter serial data |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_sck | output | 1 | Serial clock to converter |
| result | output | RES_W+2 | Signed measurement |
| out_of_range | output | 1 | Input outside 0..full scale |
| sub_lsb | output | SUB_W | Bits below the result LSB |
| valid | output | 1 | One-cycle strobe for a finished frame |
| frame_err | output | 1 | Status bits of the frame were wrong |
| timeout | output | 1 | One-cycle strobe for an abandoned wait |

## Verification
Every result is due at a cycle that can be computed from the stimulus. `adc_cs_n` falls one clock after `start`. The timeout strobe comes exactly `timeout_cfg`+1 clocks later. On a good frame, `valid` and the decoded outputs appear W + 63·(`div_cfg`+1) + 1 clocks after chip select fell. The bench plays the converter: it changes data only after a falling serial-clock edge and samples everything on the falling system-clock edge. For each frame it counts the chip-select low clocks and the serial-clock rising edges and compares both with these formulas. It reads the outputs in the exact cycle where chip select returns high, and again one clock later to confirm the strobes were single pulses. The wait boundary is tested on both sides: a conversion that finishes on the last allowed clock, and one that finishes a clock too late.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SHIFT,
    ST_DONE
  } rd_state_t;

  localparam int HDR_W = 4;
endpackage

// File: rtl/adc_rd_sck_gen.sv
module adc_rd_sck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             sck,
  output logic             rise
);
  logic [DIV_W-1:0] cnt;

  // strobe for the clock edge on which sck goes from low to high
  assign rise = run && (cnt == half_div) && !sck;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (cnt == half_div) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_sck_parks_low_R4: assert property (@(posedge clk) disable iff (rst)
    !run |=> !sck);
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               en,
  input  logic               din,
  output logic [FRAME_W-1:0] frame,
  output logic               last
);
  localparam int CNT_W = $clog2(FRAME_W);

  logic [CNT_W-1:0] bit_cnt;

  assign last = en && (bit_cnt == CNT_W'(FRAME_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      frame   <= '0;
    end else if (clear) begin
      bit_cnt <= '0;
    end else if (en) begin
      frame   <= {frame[FRAME_W-2:0], din};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assert_count_restarts_R5: assert property (@(posedge clk) disable iff (rst)
    clear |=> (bit_cnt == '0));
endmodule

// File: rtl/adc_rd_decode.sv
module adc_rd_decode #(
  parameter int RES_W = 24,
  parameter int SUB_W = 4
) (
  input  logic [adc_rd_pkg::HDR_W+RES_W+SUB_W-1:0] frame,
  output logic signed [RES_W+1:0]                  value,
  output logic                                     range_flag,
  output logic [SUB_W-1:0]                         sub_bits,
  output logic                                     bad
);
  localparam int FRAME_W = adc_rd_pkg::HDR_W + RES_W + SUB_W;

  logic busy_bit, dummy_bit, sign_bit;

  assign busy_bit   = frame[FRAME_W-1];
  assign dummy_bit  = frame[FRAME_W-2];
  assign sign_bit   = frame[FRAME_W-3];
  assign range_flag = frame[FRAME_W-4];
  assign sub_bits   = frame[SUB_W-1:0];
  assign value      = $signed({~sign_bit, range_flag, frame[SUB_W+RES_W-1:SUB_W]});
  assign bad        = busy_bit | dummy_bit;
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int RES_W = 24,
  parameter int SUB_W = 4,
  parameter int DIV_W = 8,
  parameter int TO_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [DIV_W-1:0]        div_cfg,
  input  logic [TO_W-1:0]         timeout_cfg,
  input  logic                    adc_sdo,
  output logic                    adc_cs_n,
  output logic                    adc_sck,
  output logic signed [RES_W+1:0] result,
  output logic                    out_of_range,
  output logic [SUB_W-1:0]        sub_lsb,
  output logic                    valid,
  output logic                    frame_err,
  output logic                    timeout
);
  import adc_rd_pkg::*;

  localparam int FRAME_W = HDR_W + RES_W + SUB_W;
  localparam int OUT_W   = RES_W + 2;

  rd_state_t          state;
  logic [TO_W-1:0]    to_cnt;
  logic               run, rise, last;
  logic [FRAME_W-1:0] frame;
  logic signed [OUT_W-1:0] dec_val;
  logic               dec_range, dec_bad;
  logic [SUB_W-1:0]   dec_sub;

  assign run = (state == ST_SHIFT);

  adc_rd_sck_gen #(.DIV_W(DIV_W)) u_sck (
    .clk(clk), .rst(rst), .run(run), .half_div(div_cfg),
    .sck(adc_sck), .rise(rise)
  );

  adc_rd_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .clear(!run), .en(rise), .din(adc_sdo),
    .frame(frame), .last(last)
  );

  adc_rd_decode #(.RES_W(RES_W), .SUB_W(SUB_W)) u_dec (
    .frame(frame), .value(dec_val), .range_flag(dec_range),
    .sub_bits(dec_sub), .bad(dec_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      adc_cs_n     <= 1'b1;
      to_cnt       <= '0;
      valid        <= 1'b0;
      timeout      <= 1'b0;
      frame_err    <= 1'b0;
      result       <= '0;
      out_of_range <= 1'b0;
      sub_lsb      <= '0;
    end else begin
      valid   <= 1'b0;
      timeout <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            adc_cs_n <= 1'b0;
            to_cnt   <= '0;
            state    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (!adc_sdo) begin
            state <= ST_SHIFT;
          end else if (to_cnt == timeout_cfg) begin
            adc_cs_n <= 1'b1;
            timeout  <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            to_cnt <= to_cnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (last) state <= ST_DONE;
        end
        default: begin
          adc_cs_n     <= 1'b1;
          valid        <= 1'b1;
          result       <= dec_val;
          out_of_range <= dec_range;
          sub_lsb      <= dec_sub;
          frame_err    <= dec_bad;
          state        <= ST_IDLE;
        end
      endcase
    end
  end

  assert_sck_needs_select_R4: assert property (@(posedge clk) disable iff (rst)
    adc_sck |-> !adc_cs_n);
  assert_quiet_while_waiting_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> !adc_sck);
  assert_valid_single_R9: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  assert_valid_at_release_R9: assert property (@(posedge clk) disable iff (rst)
    valid |-> (adc_cs_n && $past(!adc_cs_n)));
  assert_timeout_excludes_valid_R3: assert property (@(posedge clk) disable iff (rst)
    !(valid && timeout));
  assert_timeout_single_R3: assert property (@(posedge clk) disable iff (rst)
    timeout |=> !timeout);
endmodule

// File: tb/adc_frame_reader_tb.sv
module adc_frame_reader_tb;
  localparam int CLK_P = 10;
  localparam int LIMIT = 150000;
  localparam longint FS = 64'sd16777216;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0]  div_cfg = '0;
  logic [15:0] timeout_cfg = '0;
  logic adc_sdo, adc_cs_n, adc_sck;
  logic signed [25:0] result;
  logic out_of_range, valid, frame_err, timeout;
  logic [3:0] sub_lsb;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic [31:0] tx = '0;
  int conv_cfg = 0;
  int conv_left = 0;
  int idx = 31;
  logic sck_q = 1'b0;

  adc_frame_reader u_dut (
    .clk(clk), .rst(rst), .start(start), .div_cfg(div_cfg),
    .timeout_cfg(timeout_cfg), .adc_sdo(adc_sdo), .adc_cs_n(adc_cs_n),
    .adc_sck(adc_sck), .result(result), .out_of_range(out_of_range),
    .sub_lsb(sub_lsb), .valid(valid), .frame_err(frame_err), .timeout(timeout)
  );

  always #(CLK_P/2) clk = ~clk;

  // converter model: busy high, then the word, updated after each sck fall
  assign adc_sdo = adc_cs_n ? 1'b1 : ((conv_left != 0) ? 1'b1 : tx[idx[4:0]]);

  always @(negedge clk) begin
    if (adc_cs_n) begin
      idx       <= 31;
      conv_left <= conv_cfg;
    end else begin
      if (conv_left != 0) conv_left <= conv_left - 1;
      if (sck_q && !adc_sck && idx > 0) idx <= idx - 1;
    end
    sck_q <= adc_sck;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == LIMIT) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<%0d cycles", cyc, LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] build(input longint v, input int sub, input bit dmy);
    bit sig, exr;
    longint m;
    sig = (v >= 0);
    exr = (v < 0) || (v >= FS);
    m = (v < 0) ? v + FS : ((v >= FS) ? v - FS : v);
    return {1'b0, dmy, sig, exr, m[23:0], 4'(sub)};
  endfunction

  task automatic run_frame(input longint v, input int sub, input bit dmy,
                           input int d, input int t, input int dv, input bit poke);
    int lowcnt, rises, w;
    bit prev;
    longint expl;
    tx = build(v, sub, dmy);
    conv_cfg = d;
    timeout_cfg = 16'(t);
    div_cfg = 8'(dv);
    @(negedge clk);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(adc_cs_n == 1'b0, "R2", "cs low after start", adc_cs_n, 0);
    lowcnt = 0; rises = 0; prev = 1'b0;
    while (adc_cs_n == 1'b0) begin
      lowcnt++;
      if (adc_sck && !prev) rises++;
      prev = adc_sck;
      start = (poke && lowcnt == 5);
      @(negedge clk);
    end
    start = 1'b0;
    w = (d > 1) ? d : 1;
    if (w <= t + 1) begin
      expl = w + 63 * (dv + 1) + 1;
      chk(lowcnt == expl, "R9", "cs low cycles", lowcnt, expl);
      chk(rises == 32, "R4", "sck rising edges", rises, 32);
      chk(valid == 1'b1, "R9", "valid at release", valid, 1);
      chk(timeout == 1'b0, "R3", "no timeout on good frame", timeout, 0);
      chk(longint'(result) == v, "R6", "signed result", longint'(result), v);
      chk(out_of_range == ((v < 0) || (v >= FS)), "R7", "range flag",
          out_of_range, ((v < 0) || (v >= FS)));
      chk(sub_lsb == 4'(sub), "R5", "sub lsb", sub_lsb, sub & 15);
      chk(frame_err == dmy, "R8", "frame error", frame_err, dmy);
    end else begin
      chk(lowcnt == t + 1, "R3", "cs low cycles on timeout", lowcnt, t + 1);
      chk(timeout == 1'b1, "R3", "timeout strobe", timeout, 1);
      chk(valid == 1'b0, "R3", "no valid on timeout", valid, 0);
      chk(rises == 0, "R2", "no sck while waiting", rises, 0);
    end
    @(negedge clk);
    chk(valid == 1'b0 && timeout == 1'b0, "R9", "strobes one cycle",
        valid | timeout, 0);
    if (poke) begin
      repeat (3) begin
        @(negedge clk);
        chk(adc_cs_n == 1'b1, "R10", "start ignored mid-frame", adc_cs_n, 1);
      end
    end
  endtask

  initial begin
    longint vals [10];
    vals[0] = 0;             vals[1] = -1;
    vals[2] = FS - 1;        vals[3] = -(FS / 8);
    vals[4] = FS + FS/8 - 1; vals[5] = FS / 2;
    vals[6] = 1;             vals[7] = FS;
    vals[8] = 12345;         vals[9] = -777;

    repeat (3) @(negedge clk);
    chk(adc_cs_n == 1'b1, "R1", "cs in reset", adc_cs_n, 1);
    chk(adc_sck == 1'b0, "R1", "sck in reset", adc_sck, 0);
    chk(valid == 1'b0 && timeout == 1'b0 && frame_err == 1'b0, "R1",
        "strobes in reset", valid | timeout | frame_err, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(adc_cs_n == 1'b1 && adc_sck == 1'b0, "R1", "idle after reset",
        adc_cs_n, 1);

    for (int dv = 0; dv < 3; dv++) begin
      for (int i = 0; i < 10; i++) begin
        run_frame(vals[i], i + 3 * dv, 1'b0, (i % 4), 20, dv, 1'b0);
      end
    end

    // frame whose dummy bit reads 1
    run_frame(4242, 9, 1'b1, 2, 20, 1, 1'b0);
    // wait boundary: last allowed clock, then one too late
    run_frame(-5, 6, 1'b0, 6, 5, 0, 1'b0);
    run_frame(77, 6, 1'b0, 7, 5, 0, 1'b0);
    // recovery after a timeout, with start poked mid-frame
    run_frame(FS / 4, 15, 1'b0, 3, 10, 2, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule